// File: doc/BRIEF.md
# Conditional Branch Resolver

This unit decides whether a conditional branch goes. It compares two 32-bit register operands under a 3-bit comparison code. A separate signedness bit picks two's-complement or unsigned ordering for the four ordering tests. The equality and inequality tests ignore that bit. Two of the eight code values are reserved. For those the unit never reports the branch as taken, and it raises an illegal-code flag instead.

The unit also produces the next program counter. When the condition holds, the next PC is the current PC plus the sign-extended 16-bit offset. When it does not hold, the next PC is the current PC plus one, because instructions are word-addressed. Both sums wrap modulo 2^32.

A parameter chooses whether the results pass through one register stage or come straight from the logic. The block has no state machine. Its only state is the optional output register, which is cleared by reset and reloaded on every clock.

Top module: `brc_unit`

## Requirements
- R1: Code 3'b000 reports taken exactly when opnd_a equals opnd_b.
- R2: Code 3'b100 reports taken exactly when opnd_a differs from opnd_b.
- R3: With signed_sel low, code 3'b001 (a greater than b) compares the operands as unsigned numbers.
- R4: With signed_sel high, codes 3'b001, 3'b010, 3'b101 and 3'b110 compare the operands as two's-complement numbers.
- R5: Code 3'b010 tests a >= b, code 3'b101 tests a < b, and code 3'b110 tests a <= b.
- R6: Codes 3'b000 and 3'b100 give the same result for either value of signed_sel.
- R7: Codes 3'b011 and 3'b111 give taken low and bad_code high. Every other code gives bad_code low.
- R8: When taken is high, next_pc equals pc_in plus offset sign-extended to 32 bits, modulo 2^32.
- R9: When taken is low, next_pc equals pc_in plus 1, modulo 2^32, so 32'hFFFFFFFF is followed by 0.
- R10: With REG_OUT=1 (the default), the outputs appear one clock after their inputs are sampled. While rst_n is low, taken, bad_code and next_pc are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 32 | First compared operand |
| opnd_b | input | 32 | Second compared operand |
| cmp_code | input | 3 | Comparison code |
| signed_sel | input | 1 | 1 = two's-complement ordering |
| pc_in | input | 32 | PC of the branch |
| offset | input | 16 | Signed branch offset |
| taken | output | 1 | Condition holds |
| bad_code | output | 1 | Reserved code seen |
| next_pc | output | 32 | Resolved next PC |

## Verification
A fault in the decode shows up as a wrong taken bit. Through R8 and R9, that also becomes a wrong next_pc, off by offset minus one. Either error appears on the very next cycle after the inputs are sampled, because the output register is rewritten on every clock. Stimulus therefore pairs operands that differ between signed and unsigned order, and operands that are equal, so that a mix-up of codes or of signedness changes the taken bit in a single cycle. The only stale state possible is a register that fails to reload or to clear, and the reset check together with back-to-back vectors exposes it at once.

// File: rtl/brc_pkg.sv
package brc_pkg;
    localparam int XLEN = 32;
    localparam int OFFW = 16;

    typedef enum logic [2:0] {
        CMP_EQ    = 3'b000,
        CMP_GT    = 3'b001,
        CMP_GE    = 3'b010,
        CMP_RSV_A = 3'b011,
        CMP_NE    = 3'b100,
        CMP_LT    = 3'b101,
        CMP_LE    = 3'b110,
        CMP_RSV_B = 3'b111
    } cmp_code_e;
endpackage

// File: rtl/brc_compare.sv
module brc_compare
    import brc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   code,
    input  logic         sgn,
    output logic         cond,
    output logic         illegal
);
    cmp_code_e op;
    logic      eq;
    logic      lt;

    assign op = cmp_code_e'(code);
    assign eq = (a == b);

    // Flipping the top bit maps two's-complement order onto unsigned order.
    logic [W-1:0] a_k;
    logic [W-1:0] b_k;
    assign a_k = {a[W-1] ^ sgn, a[W-2:0]};
    assign b_k = {b[W-1] ^ sgn, b[W-2:0]};
    assign lt  = (a_k < b_k);

    always_comb begin
        cond    = 1'b0;
        illegal = 1'b0;
        unique case (op)
            CMP_EQ:    cond = eq;
            CMP_NE:    cond = !eq;
            CMP_GT:    cond = !lt && !eq;
            CMP_GE:    cond = !lt;
            CMP_LT:    cond = lt;
            CMP_LE:    cond = lt || eq;
            CMP_RSV_A,
            CMP_RSV_B: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
    parameter int W  = 32,
    parameter int OW = 16
) (
    input  logic [W-1:0]  pc,
    input  logic [OW-1:0] off,
    input  logic          go,
    output logic [W-1:0]  npc
);
    localparam int EXT = W - OW;

    logic [W-1:0] off_x;
    logic [W-1:0] jump_pc;
    logic [W-1:0] seq_pc;

    assign off_x   = {{EXT{off[OW-1]}}, off};
    assign jump_pc = pc + off_x;
    assign seq_pc  = pc + {{(W-1){1'b0}}, 1'b1};
    assign npc     = go ? jump_pc : seq_pc;
endmodule

// File: rtl/brc_stage.sv
module brc_stage #(
    parameter int W   = 34,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REG) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
            assign q = q_r;
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [2:0]      cmp_code,
    input  logic            signed_sel,
    input  logic [XLEN-1:0] pc_in,
    input  logic [OFFW-1:0] offset,
    output logic            taken,
    output logic            bad_code,
    output logic [XLEN-1:0] next_pc
);
    localparam int PW = XLEN + 2;

    logic            cond_c;
    logic            ill_c;
    logic [XLEN-1:0] npc_c;
    logic [PW-1:0]   pack_d;
    logic [PW-1:0]   pack_q;

    brc_compare #(.W(XLEN)) u_cmp (
        .a(opnd_a), .b(opnd_b), .code(cmp_code), .sgn(signed_sel),
        .cond(cond_c), .illegal(ill_c)
    );

    brc_target #(.W(XLEN), .OW(OFFW)) u_tgt (
        .pc(pc_in), .off(offset), .go(cond_c), .npc(npc_c)
    );

    assign pack_d = {cond_c, ill_c, npc_c};

    brc_stage #(.W(PW), .REG(REG_OUT)) u_stg (
        .clk(clk), .rst_n(rst_n), .d(pack_d), .q(pack_q)
    );

    assign taken    = pack_q[PW-1];
    assign bad_code = pack_q[PW-2];
    assign next_pc  = pack_q[XLEN-1:0];
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [2:0]  cmp_code,
    input logic        signed_sel,
    input logic [31:0] pc_in,
    input logic [15:0] offset,
    input logic        taken,
    input logic        bad_code,
    input logic [31:0] next_pc
);
    logic primed;
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    generate
        if (REG_OUT) begin : g_seq
            // R7
            rsv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                primed && $past(cmp_code[1:0] == 2'b11) |-> bad_code && !taken);
            // R7
            legal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                primed && $past(cmp_code[1:0] != 2'b11) |-> !bad_code);
            // R1
            eq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
                primed && $past(cmp_code == 3'b000) |-> taken == ($past(opnd_a) == $past(opnd_b)));
            // R2
            ne_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
                primed && $past(cmp_code == 3'b100) |-> taken == ($past(opnd_a) != $past(opnd_b)));
            // R8
            jump_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
                primed && taken |-> next_pc == $past(pc_in) + {{16{$past(offset[15])}}, $past(offset)});
            // R9
            seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
                primed && !taken |-> next_pc == $past(pc_in) + 32'd1);
        end else begin : g_comb
            // R7
            rsv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cmp_code[1:0] == 2'b11 |-> bad_code && !taken);
            // R8
            jump_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
                taken |-> next_pc == pc_in + {{16{offset[15]}}, offset});
            // R9
            seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !taken |-> next_pc == pc_in + 32'd1);
            // R1
            eq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cmp_code == 3'b000 |-> taken == (opnd_a == opnd_b));
        end
    endgenerate
endmodule

bind brc_unit brc_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .cmp_code(cmp_code), .signed_sel(signed_sel), .pc_in(pc_in),
    .offset(offset), .taken(taken), .bad_code(bad_code), .next_pc(next_pc)
);

// File: tb/test_brc_unit.sv
module test_brc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [2:0]  cmp_code = '0;
    logic        signed_sel = 1'b0;
    logic [31:0] pc_in = '0;
    logic [15:0] offset = '0;
    logic        taken;
    logic        bad_code;
    logic [31:0] next_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit running = 1'b1;

    always #5 clk = ~clk;

    brc_unit i_brc_unit (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .cmp_code(cmp_code), .signed_sel(signed_sel), .pc_in(pc_in),
        .offset(offset), .taken(taken), .bad_code(bad_code), .next_pc(next_pc)
    );

    typedef struct {
        logic        tk;
        logic        ill;
        logic [31:0] npc;
        string       tag;
    } exp_t;

    exp_t sb[$];

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected model taken straight from the requirement list.
    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] c, input logic s,
                         input logic [31:0] pc, input logic [15:0] off,
                         input string tag);
        exp_t e;
        logic gt, lt, eq;
        eq = (a == b);
        if (s) begin
            lt = $signed(a) < $signed(b);
            gt = $signed(a) > $signed(b);
        end else begin
            lt = a < b;
            gt = a > b;
        end
        e.ill = (c == 3'b011) || (c == 3'b111);
        case (c)
            3'b000: e.tk = eq;
            3'b100: e.tk = !eq;
            3'b001: e.tk = gt;
            3'b010: e.tk = gt || eq;
            3'b101: e.tk = lt;
            3'b110: e.tk = lt || eq;
            default: e.tk = 1'b0;
        endcase
        e.npc = e.tk ? pc + {{16{off[15]}}, off} : pc + 32'd1;
        e.tag = tag;
        @(negedge clk);
        opnd_a = a; opnd_b = b; cmp_code = c; signed_sel = s;
        pc_in = pc; offset = off;
        sb.push_back(e);
    endtask

    // Monitor: outputs settle after the edge that samples the inputs (R10).
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "taken", {31'd0, taken}, {31'd0, e.tk});
                check(e.tag, "bad_code", {31'd0, bad_code}, {31'd0, e.ill});
                check(e.tag, "next_pc", next_pc, e.npc);
            end
        end
    end

    initial begin
        #2_000_000;
        if (running) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        opnd_a = 32'h1234; cmp_code = 3'b100; pc_in = 32'h55;
        repeat (3) @(posedge clk);
        #2;
        // R10 reset state
        check("R10", "reset taken", {31'd0, taken}, 32'd0);
        check("R10", "reset bad_code", {31'd0, bad_code}, 32'd0);
        check("R10", "reset next_pc", next_pc, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(32'd7, 32'd7, 3'b000, 1'b0, 32'h100, 16'h0010, "R1");
        drive(32'd7, 32'd8, 3'b000, 1'b0, 32'h100, 16'h0010, "R1");
        drive(32'd7, 32'd7, 3'b000, 1'b1, 32'h200, 16'h0004, "R6");
        drive(32'd3, 32'd9, 3'b100, 1'b0, 32'h300, 16'h0020, "R2");
        drive(32'd3, 32'd3, 3'b100, 1'b1, 32'h300, 16'h0020, "R6");
        drive(32'hFFFFFFFF, 32'd1, 3'b001, 1'b0, 32'h40, 16'h0008, "R3");
        drive(32'hFFFFFFFF, 32'd1, 3'b001, 1'b1, 32'h40, 16'h0008, "R4");
        drive(32'd1, 32'h80000000, 3'b101, 1'b1, 32'h50, 16'hFFFC, "R4");
        drive(32'd1, 32'h80000000, 3'b101, 1'b0, 32'h50, 16'hFFFC, "R5");
        drive(32'd5, 32'd5, 3'b010, 1'b0, 32'h60, 16'h0002, "R5");
        drive(32'hFFFFFFFE, 32'hFFFFFFFE, 3'b110, 1'b1, 32'h70, 16'h0003, "R5");
        drive(32'h80000000, 32'h7FFFFFFF, 3'b110, 1'b1, 32'h70, 16'h0003, "R4");
        drive(32'h80000000, 32'h7FFFFFFF, 3'b010, 1'b1, 32'h70, 16'h0003, "R4");
        drive(32'd4, 32'd4, 3'b011, 1'b0, 32'h80, 16'h0010, "R7");
        drive(32'd9, 32'd4, 3'b111, 1'b1, 32'h80, 16'h0010, "R7");
        drive(32'd2, 32'd2, 3'b000, 1'b0, 32'h1000, 16'h8000, "R8");
        drive(32'd2, 32'd2, 3'b000, 1'b0, 32'hFFFFFFF0, 16'h0020, "R8");
        drive(32'd2, 32'd3, 3'b000, 1'b0, 32'hFFFFFFFF, 16'h0020, "R9");
        drive(32'd2, 32'd3, 3'b000, 1'b0, 32'h0, 16'h0020, "R9");
        repeat (3) @(posedge clk);
        #3;
        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule